// File: doc/BRIEF.md
# Prefixed Variable-Length Instruction Assembler

This block sits between program memory and an instruction decoder. It reads a stream of 8-bit bytes, one per accepted handshake, and groups them into whole instructions. A leading page-select byte can move the following opcode off the default page 0 onto one of three further pages. After the opcode the block collects zero to three operand bytes. It then presents the page, the opcode, the operands, the addressing mode, the total length and an effective address together, with a one-cycle valid strobe.

The block keeps its own 16-bit fetch address. That address advances once for each byte accepted. The effective address is formed only for immediate and direct operands. For every other mode the block reports the mode and the raw operand bytes and leaves the arithmetic to the consumer. Opcodes that the per-page table does not list are reported as illegal, and parsing starts again with the next byte.

Top module: `paged_opcode_fetch`

## Requirements
- R1: A first byte that is not a page-select value is decoded as an opcode on page 0 (`ins_page` = 0). The instruction length is then 1 plus its operand count.
- R2: The first-byte values 0x18, 0x1A and 0xCD select pages 1, 2 and 3 respectively. The page-select byte counts toward `ins_len`.
- R3: The byte that follows a page-select byte is always an opcode on the selected page, even when its value equals a page-select value.
- R4: Mode codes are: 0 inherent, 1 immediate, 2 direct, 3 extended, 4 indexed, 5 relative. The mode and operand count are keyed by page and opcode high nibble.
  - Page 0: nibbles 0/3/4/5 are inherent with 0 operands; 1 is indexed with 3; 2 is relative with 1; 6/A/E are indexed with 1; 7/B/F are extended with 2; 8 is immediate with 1; C is immediate with 2; 9/D are direct with 1.
  - Page 1: 0/3 are inherent with 0; 1 is indexed with 3; 6/A/E are indexed with 1; 7/B/F are extended with 2; 8/C are immediate with 2; 9/D are direct with 1.
  - Page 2: 8 is immediate with 2; 9 is direct with 1; A is indexed with 1; B is extended with 2.
  - Page 3: 8 is immediate with 2; 9 is direct with 1; A/E are indexed with 1; B/F are extended with 2.
- R5: For immediate mode, `ins_ea` is the address of the first operand byte. For modes other than immediate and direct, `ins_ea` is 0.
- R6: For direct mode, `ins_ea` is {0x00, first operand byte}.
- R7: Operand bytes are packed first-received in bits 7:0, second in 15:8 and third in 23:16, with unused bytes zero. `ins_len` ranges from 1 to 5.
- R8: A page/nibble pair not listed in R4 gives a strobe with `ins_illegal` = 1, mode 0, no operands and length 2. The next byte starts a new instruction on page 0.
- R9: `fetch_addr` increases by one for each accepted byte (`in_valid` and `in_ready` both high). It holds while no byte is accepted, including stalls inside an instruction.
- R10: `ins_valid` is high for exactly the cycle after the last byte of an instruction is accepted. The output fields hold their values until the next strobe.
- R11: A synchronous reset sets `fetch_addr` to RESET_PC, clears any partial instruction and returns the page to 0. It keeps `ins_valid` low and holds `in_ready` low while asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte on `in_byte` is valid |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| fetch_addr | output | 16 | Address of the next byte to fetch |
| ins_valid | output | 1 | Completed instruction strobe |
| ins_illegal | output | 1 | Completed item was an unlisted opcode |
| ins_page | output | 2 | Opcode page 0 to 3 |
| ins_opcode | output | 8 | Opcode byte |
| ins_operands | output | 24 | Operand bytes, first in the low byte |
| ins_mode | output | 3 | Addressing mode code |
| ins_len | output | 3 | Total length in bytes, 1 to 5 |
| ins_ea | output | 16 | Effective address (immediate or direct) |

## Verification
The bench feeds page-select values in the opcode position, for example 0x18 then 0x1A. A parser that reopened the prefix state would lose the page, or report a four-byte instruction with the wrong operands. A five-byte indexed instruction and the direct operand 0xFF cover the widest length and the top of the zero-page window, where a truncated counter or a non-zero high byte would show. Illegal opcodes are followed straight away by a plain page-0 byte, so a parser that failed to recover would mis-page or swallow it. A reset in the middle of a prefixed instruction is followed by an opcode whose length differs between page 0 and page 1, so a page that survived reset gives the wrong length. Stalls inside an instruction show whether the fetch address drifts or the strobe fires early.

// File: rtl/paged_opcode_fetch.sv
module paged_opcode_fetch #(
  parameter logic [15:0] RESET_PC = 16'hE000,
  parameter logic [7:0]  SEL_P1   = 8'h18,
  parameter logic [7:0]  SEL_P2   = 8'h1A,
  parameter logic [7:0]  SEL_P3   = 8'hCD
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic [15:0] fetch_addr,
  output logic        ins_valid,
  output logic        ins_illegal,
  output logic [1:0]  ins_page,
  output logic [7:0]  ins_opcode,
  output logic [23:0] ins_operands,
  output logic [2:0]  ins_mode,
  output logic [2:0]  ins_len,
  output logic [15:0] ins_ea
);

  localparam logic [2:0] M_INH = 3'd0;
  localparam logic [2:0] M_IMM = 3'd1;
  localparam logic [2:0] M_DIR = 3'd2;
  localparam logic [2:0] M_EXT = 3'd3;
  localparam logic [2:0] M_IDX = 3'd4;
  localparam logic [2:0] M_REL = 3'd5;

  typedef enum logic [1:0] {ST_LEAD, ST_OPC, ST_OPND} st_t;

  // returns {legal, mode, operand count}
  function automatic logic [5:0] lut(input logic [1:0] pg, input logic [3:0] nb);
    logic [5:0] r;
    r = {1'b0, M_INH, 2'd0};
    case (pg)
      2'd0:
        case (nb)
          4'h0, 4'h3, 4'h4, 4'h5: r = {1'b1, M_INH, 2'd0};
          4'h1:                   r = {1'b1, M_IDX, 2'd3};
          4'h2:                   r = {1'b1, M_REL, 2'd1};
          4'h6, 4'hA, 4'hE:       r = {1'b1, M_IDX, 2'd1};
          4'h7, 4'hB, 4'hF:       r = {1'b1, M_EXT, 2'd2};
          4'h8:                   r = {1'b1, M_IMM, 2'd1};
          4'hC:                   r = {1'b1, M_IMM, 2'd2};
          default:                r = {1'b1, M_DIR, 2'd1};
        endcase
      2'd1:
        case (nb)
          4'h0, 4'h3:             r = {1'b1, M_INH, 2'd0};
          4'h1:                   r = {1'b1, M_IDX, 2'd3};
          4'h6, 4'hA, 4'hE:       r = {1'b1, M_IDX, 2'd1};
          4'h7, 4'hB, 4'hF:       r = {1'b1, M_EXT, 2'd2};
          4'h8, 4'hC:             r = {1'b1, M_IMM, 2'd2};
          4'h9, 4'hD:             r = {1'b1, M_DIR, 2'd1};
          default:                r = {1'b0, M_INH, 2'd0};
        endcase
      2'd2:
        case (nb)
          4'h8:                   r = {1'b1, M_IMM, 2'd2};
          4'h9:                   r = {1'b1, M_DIR, 2'd1};
          4'hA:                   r = {1'b1, M_IDX, 2'd1};
          4'hB:                   r = {1'b1, M_EXT, 2'd2};
          default:                r = {1'b0, M_INH, 2'd0};
        endcase
      default:
        case (nb)
          4'h8:                   r = {1'b1, M_IMM, 2'd2};
          4'h9:                   r = {1'b1, M_DIR, 2'd1};
          4'hA, 4'hE:             r = {1'b1, M_IDX, 2'd1};
          4'hB, 4'hF:             r = {1'b1, M_EXT, 2'd2};
          default:                r = {1'b0, M_INH, 2'd0};
        endcase
    endcase
    return r;
  endfunction

  st_t         st;
  logic [15:0] pc;
  logic [1:0]  w_page;
  logic [7:0]  w_op;
  logic [2:0]  w_mode;
  logic [1:0]  w_cnt, w_got;
  logic [23:0] w_opr;
  logic [15:0] w_ea;

  logic        acc, is_sel, lu_legal;
  logic [1:0]  sel_page, cur_page, lu_cnt;
  logic [2:0]  lu_mode;
  logic [23:0] nxt_opr;

  assign in_ready   = ~rst;
  assign fetch_addr = pc;
  assign acc        = in_valid & in_ready;
  assign is_sel     = (st == ST_LEAD) &&
                      (in_byte == SEL_P1 || in_byte == SEL_P2 || in_byte == SEL_P3);
  assign sel_page   = (in_byte == SEL_P1) ? 2'd1 : (in_byte == SEL_P2) ? 2'd2 : 2'd3;
  assign cur_page   = (st == ST_LEAD) ? 2'd0 : w_page;
  assign {lu_legal, lu_mode, lu_cnt} = lut(cur_page, in_byte[7:4]);

  always_comb begin
    case (w_got)
      2'd0:    nxt_opr = {w_opr[23:8], in_byte};
      2'd1:    nxt_opr = {w_opr[23:16], in_byte, w_opr[7:0]};
      default: nxt_opr = {in_byte, w_opr[15:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_LEAD;
      pc           <= RESET_PC;
      w_page       <= 2'd0;
      w_op         <= 8'h00;
      w_mode       <= M_INH;
      w_cnt        <= 2'd0;
      w_got        <= 2'd0;
      w_opr        <= 24'h0;
      w_ea         <= 16'h0;
      ins_valid    <= 1'b0;
      ins_illegal  <= 1'b0;
      ins_page     <= 2'd0;
      ins_opcode   <= 8'h00;
      ins_operands <= 24'h0;
      ins_mode     <= M_INH;
      ins_len      <= 3'd0;
      ins_ea       <= 16'h0;
    end else begin
      ins_valid <= 1'b0;
      if (acc) begin
        pc <= pc + 16'd1;
        if (st == ST_OPND) begin
          w_opr <= nxt_opr;
          if (w_got + 2'd1 == w_cnt) begin
            ins_valid    <= 1'b1;
            ins_illegal  <= 1'b0;
            ins_page     <= w_page;
            ins_opcode   <= w_op;
            ins_operands <= nxt_opr;
            ins_mode     <= w_mode;
            ins_len      <= 3'd1 + {2'd0, w_page != 2'd0} + {1'b0, w_cnt};
            ins_ea       <= (w_mode == M_DIR) ? {8'h00, nxt_opr[7:0]} : w_ea;
            st           <= ST_LEAD;
            w_page       <= 2'd0;
          end else begin
            w_got <= w_got + 2'd1;
          end
        end else if (is_sel) begin
          w_page <= sel_page;
          st     <= ST_OPC;
        end else begin
          w_op   <= in_byte;
          w_mode <= lu_mode;
          w_cnt  <= lu_cnt;
          w_got  <= 2'd0;
          w_opr  <= 24'h0;
          w_ea   <= (lu_mode == M_IMM) ? pc + 16'd1 : 16'h0;
          if (!lu_legal || lu_cnt == 2'd0) begin
            ins_valid    <= 1'b1;
            ins_illegal  <= ~lu_legal;
            ins_page     <= cur_page;
            ins_opcode   <= in_byte;
            ins_operands <= 24'h0;
            ins_mode     <= lu_legal ? lu_mode : M_INH;
            ins_len      <= (st == ST_OPC) ? 3'd2 : 3'd1;
            ins_ea       <= 16'h0;
            st           <= ST_LEAD;
            w_page       <= 2'd0;
          end else begin
            st <= ST_OPND;
          end
        end
      end
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    acc |=> fetch_addr == $past(fetch_addr) + 16'd1); // R9
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(fetch_addr)); // R9
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> (ins_len >= 3'd1 && ins_len <= 3'd5)); // R7
  AST_SEL_LEN: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_page != 2'd0) |-> ins_len >= 3'd2); // R2
  AST_IMM_EA: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !ins_illegal && ins_mode == M_IMM) |->
    ins_ea == fetch_addr - {13'd0, ins_len} + 16'd1 + {15'd0, ins_page != 2'd0}); // R5
  AST_DIR_EA: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_mode == M_DIR) |-> ins_ea == {8'h00, ins_operands[7:0]}); // R6
  AST_ILL_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_illegal) |->
    (ins_len == 3'd2 && ins_page != 2'd0 && ins_operands == 24'h0)); // R8
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!ins_valid && fetch_addr == RESET_PC)); // R11

endmodule

// File: tb/tb_paged_opcode_fetch.sv
`timescale 1ns/1ps
module tb_paged_opcode_fetch;
  localparam logic [15:0] RPC = 16'hE000;
  localparam int NV = 19;
  // {nbytes[3], bytes[40] first in msb, page[2], op[8], opr[24], mode[3], len[3], illegal[1]}
  localparam logic [83:0] VEC [NV] = '{
    {3'd1, 40'h01_00_00_00_00, 2'd0, 8'h01, 24'h000000, 3'd0, 3'd1, 1'b0},
    {3'd2, 40'h86_55_00_00_00, 2'd0, 8'h86, 24'h000055, 3'd1, 3'd2, 1'b0},
    {3'd3, 40'hCC_12_34_00_00, 2'd0, 8'hCC, 24'h003412, 3'd1, 3'd3, 1'b0},
    {3'd2, 40'h96_40_00_00_00, 2'd0, 8'h96, 24'h000040, 3'd2, 3'd2, 1'b0},
    {3'd2, 40'hD7_FF_00_00_00, 2'd0, 8'hD7, 24'h0000FF, 3'd2, 3'd2, 1'b0},
    {3'd3, 40'hB6_12_34_00_00, 2'd0, 8'hB6, 24'h003412, 3'd3, 3'd3, 1'b0},
    {3'd2, 40'h20_05_00_00_00, 2'd0, 8'h20, 24'h000005, 3'd5, 3'd2, 1'b0},
    {3'd2, 40'hA6_07_00_00_00, 2'd0, 8'hA6, 24'h000007, 3'd4, 3'd2, 1'b0},
    {3'd4, 40'h1C_01_02_03_00, 2'd0, 8'h1C, 24'h030201, 3'd4, 3'd4, 1'b0},
    {3'd4, 40'h18_8C_AB_CD_00, 2'd1, 8'h8C, 24'h00CDAB, 3'd1, 3'd4, 1'b0},
    {3'd3, 40'h1A_93_21_00_00, 2'd2, 8'h93, 24'h000021, 3'd2, 3'd3, 1'b0},
    {3'd3, 40'hCD_A3_09_00_00, 2'd3, 8'hA3, 24'h000009, 3'd4, 3'd3, 1'b0},
    {3'd5, 40'h18_1A_01_02_03, 2'd1, 8'h1A, 24'h030201, 3'd4, 3'd5, 1'b0},
    {3'd2, 40'hCD_18_00_00_00, 2'd3, 8'h18, 24'h000000, 3'd0, 3'd2, 1'b1},
    {3'd2, 40'h1A_00_00_00_00, 2'd2, 8'h00, 24'h000000, 3'd0, 3'd2, 1'b1},
    {3'd1, 40'h30_00_00_00_00, 2'd0, 8'h30, 24'h000000, 3'd0, 3'd1, 1'b0},
    {3'd2, 40'h18_30_00_00_00, 2'd1, 8'h30, 24'h000000, 3'd0, 3'd2, 1'b0},
    {3'd4, 40'hCD_8F_11_22_00, 2'd3, 8'h8F, 24'h002211, 3'd1, 3'd4, 1'b0},
    {3'd2, 40'h1A_CD_00_00_00, 2'd2, 8'hCD, 24'h000000, 3'd0, 3'd2, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, ins_valid, ins_illegal;
  logic [15:0] fetch_addr, ins_ea;
  logic [1:0] ins_page;
  logic [7:0] ins_opcode;
  logic [23:0] ins_operands;
  logic [2:0] ins_mode, ins_len;
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [15:0] exp_pc;

  always #2 clk = ~clk;

  paged_opcode_fetch #(.RESET_PC(RPC)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .fetch_addr(fetch_addr), .ins_valid(ins_valid), .ins_illegal(ins_illegal),
    .ins_page(ins_page), .ins_opcode(ins_opcode), .ins_operands(ins_operands),
    .ins_mode(ins_mode), .ins_len(ins_len), .ins_ea(ins_ea));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic feed(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    exp_pc = exp_pc + 16'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [83:0] v;
    logic [15:0] start, eea;
    logic [2:0] nb;
    exp_pc = RPC;
    idle(3);
    chk("R11 ready low in reset", in_ready, 0);
    chk("R11 no strobe in reset", ins_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset pc", fetch_addr, RPC);
    chk("R11 ready after reset", in_ready, 1);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i]; nb = v[83:81]; start = exp_pc;
      for (int k = 0; k < nb; k++) begin
        feed(v[80 - 8*k -: 8]);
        if (k < nb - 1) chk("R10 no strobe mid", ins_valid, 0);
      end
      chk("R10 strobe", ins_valid, 1);
      chk("R1 R2 R3 page", ins_page, v[40:39]);
      chk("R3 opcode", ins_opcode, v[38:31]);
      chk("R7 operands", ins_operands, v[30:7]);
      chk("R4 mode", ins_mode, v[6:4]);
      chk("R7 length", ins_len, v[3:1]);
      chk("R8 illegal", ins_illegal, v[0]);
      if (v[6:4] == 3'd1 && !v[0]) eea = start + 16'd1 + {15'd0, v[40:39] != 2'd0};
      else if (v[6:4] == 3'd2) eea = {8'h00, v[14:7]};
      else eea = 16'h0;
      chk("R5 R6 ea", ins_ea, eea);
      chk("R9 fetch addr", fetch_addr, exp_pc);
    end

    start = exp_pc;
    feed(8'h18); idle(3);
    chk("R9 pc stalled", fetch_addr, exp_pc);
    chk("R10 no strobe stalled", ins_valid, 0);
    feed(8'h8C); idle(2);
    feed(8'hAA); idle(1);
    chk("R9 pc stalled opnd", fetch_addr, exp_pc);
    feed(8'hBB);
    chk("R10 stalled strobe", ins_valid, 1);
    chk("R7 stalled operands", ins_operands, 24'h00BBAA);
    chk("R5 stalled ea", ins_ea, start + 16'd2);
    chk("R2 stalled len", ins_len, 4);
    idle(1);
    chk("R10 strobe one cycle", ins_valid, 0);
    chk("R10 fields held", ins_opcode, 8'h8C);

    feed(8'h18); feed(8'hCC); feed(8'h01);
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    exp_pc = RPC;
    chk("R11 mid reset pc", fetch_addr, RPC);
    chk("R11 mid reset strobe", ins_valid, 0);
    feed(8'h86); feed(8'h77);
    chk("R11 page cleared", ins_page, 0);
    chk("R11 len page0", ins_len, 2);
    chk("R11 operand", ins_operands, 24'h000077);
    chk("R11 ea", ins_ea, RPC + 16'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule